// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Two-Step Entry Load

This block is a small, fully associative address translation buffer. Each of its entries covers an inclusive virtual range from a begin address to an end address. It also holds a physical page number, a packed group of protection fields and a valid bit. A combinational lookup port turns a virtual address into a hit flag, a physical address and the protection fields of the entry that hits. Checking permissions and raising faults is left to the logic that uses the block.

Software-style commands arrive on a single command port, and each one completes on one clock edge. An entry is built in two steps:

- An insert-address command places the page range and the physical page number into a slot. The entry is still invalid after this step.
- A following insert-protection command to an address inside that range loads the protection fields and marks the entry valid.

Two purge commands remove entries: one removes a single entry by address, the other clears the whole buffer. When an insert finds no free slot, a round-robin pointer picks the victim.

Top module: `range_tlb`

## Requirements
- R1: After reset every entry is in the cleared state and the round-robin pointer is 0. Every lookup misses, and `cmd_err_o` is low.
- R2: Insert-address (op code 0) sets the entry's begin to `cmd_addr_i` with its low 12 bits cleared. It sets the end to begin + 4095 and the page number to `cmd_data_i[24:5]`. The entry stays invalid, so a lookup in that range misses.
- R3: Insert-protection (op code 1) acts on the lowest-index entry whose range holds `cmd_addr_i`, when that entry is invalid. It copies `cmd_data_i[29:1]` into the entry's protection fields and makes the entry valid. A later lookup in the range hits with `lk_prot_o` equal to those 29 bits and `lk_pa_o` = {page number, `lk_addr_i[11:0]`}.
- R4: Ranges are inclusive. The begin and end addresses hit, while begin-1 and end+1 miss. On a miss, `lk_pa_o` and `lk_prot_o` are zero.
- R5: Insert-protection changes nothing in two cases: no entry's range holds the address, or the first matching entry is already valid. In both cases `cmd_err_o` is high for the one cycle that follows the command edge.
- R6: Purge-by-address (op code 2) clears the first entry whose range holds the address, but only if that entry is valid. Other entries are untouched. An address that matches nothing has no effect.
- R7: Purge-all (op code 3) returns every entry to the cleared state.
- R8: Insert-address clears every valid entry whose range holds the address. It writes the highest-index entry that is either invalid or was one of those covering entries.
- R9: When every entry is valid and none covers the address, insert-address overwrites the entry at the round-robin pointer. The pointer then advances by one and wraps from the last entry to 0.
- R10: A lookup presented in the same cycle as a command sees the contents from before that command's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 2 | 0 insert-address, 1 insert-protection, 2 purge-by-address, 3 purge-all |
| cmd_addr_i | input | VA_W | Virtual address operand |
| cmd_data_i | input | OP_W | Operand word for insert commands |
| lk_addr_i | input | VA_W | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup found a valid entry |
| lk_pa_o | output | PPN_W+PAGE_BITS | Translated physical address, zero on miss |
| lk_prot_o | output | 29 | Protection fields of the hit entry, zero on miss |
| cmd_err_o | output | 1 | Insert-protection rejected, one-cycle pulse |

## Verification
A lookup and a command can fall in the same cycle. The case of most interest is an insert-protection or purge aimed at the very address being looked up. The bench drives both in one cycle. It expects the lookup to report the contents from before the edge: a miss before the protection step and a hit before a purge. It then repeats the lookup in the next cycle and expects the post-command result, which is judged against a reference model kept in the bench.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

  typedef enum logic [1:0] {
    OP_INS_ADDR  = 2'd0,
    OP_INS_PROT  = 2'd1,
    OP_PURGE_VA  = 2'd2,
    OP_PURGE_ALL = 2'd3
  } tlb_op_e;

  // protection group, packed so that it mirrors operand bits [29:1]
  typedef struct packed {
    logic       trap_ref;
    logic       dirty;
    logic       brk;
    logic [2:0] acc_kind;
    logic [1:0] priv_hi;
    logic [1:0] priv_lo;
    logic       usr;
    logic [17:0] acc_id;
  } prot_t;

  localparam int PROT_W   = $bits(prot_t);
  localparam int PROT_LSB = 1;

endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match #(
  parameter int N  = 8,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][AW-1:0] lo_i,
  input  logic [N-1:0][AW-1:0] hi_i,
  input  logic [AW-1:0]        addr_i,
  output logic [N-1:0]         hit_vec_o,
  output logic                 any_o,
  output logic [IW-1:0]        first_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = (lo_i[g] <= addr_i) && (addr_i <= hi_i[g]);
  end

  assign any_o = |hit_vec_o;

  // lowest index wins
  always_comb begin
    first_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) first_o = IW'(i);
    end
  end

endmodule

// File: rtl/range_tlb_pick.sv
module range_tlb_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  cover_i,
  input  logic [IW-1:0] rr_i,
  output logic [IW-1:0] slot_o,
  output logic          use_rr_o
);

  // last free slot in scan order; fall back to round-robin victim
  always_comb begin
    slot_o   = rr_i;
    use_rr_o = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] || cover_i[i]) begin
        slot_o   = IW'(i);
        use_rr_o = 1'b0;
      end
    end
  end

endmodule

// File: rtl/range_tlb_rr.sv
module range_tlb_rr #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int OP_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int PPN_LSB   = 5,
  localparam int PA_W     = PPN_W + PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [VA_W-1:0]   cmd_addr_i,
  input  logic [OP_W-1:0]   cmd_data_i,
  input  logic [VA_W-1:0]   lk_addr_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [PROT_W-1:0] lk_prot_o,
  output logic              cmd_err_o
);

  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [VA_W-1:0] OFF_MASK =
    {{(VA_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  // entry storage, gathered from the per-entry registers below
  logic [N_ENTRIES-1:0][VA_W-1:0]  lo_q, hi_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_q;
  prot_t [N_ENTRIES-1:0]           prot_q;
  logic [N_ENTRIES-1:0]            valid_q;

  tlb_op_e op;
  logic    ins_addr, ins_prot, purge_va, purge_all;

  assign op        = tlb_op_e'(cmd_op_i);
  assign ins_addr  = cmd_valid_i && (op == OP_INS_ADDR);
  assign ins_prot  = cmd_valid_i && (op == OP_INS_PROT);
  assign purge_va  = cmd_valid_i && (op == OP_PURGE_VA);
  assign purge_all = cmd_valid_i && (op == OP_PURGE_ALL);

  // command-side range match
  logic [N_ENTRIES-1:0] cm_vec;
  logic                 cm_any;
  logic [IW-1:0]        cm_idx;

  range_tlb_match #(.N(N_ENTRIES), .AW(VA_W)) u_cmd_match (
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .addr_i   (cmd_addr_i),
    .hit_vec_o(cm_vec),
    .any_o    (cm_any),
    .first_o  (cm_idx)
  );

  // lookup-side range match
  logic [N_ENTRIES-1:0] lk_vec;
  logic                 lk_any;
  logic [IW-1:0]        lk_idx;

  range_tlb_match #(.N(N_ENTRIES), .AW(VA_W)) u_lk_match (
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .addr_i   (lk_addr_i),
    .hit_vec_o(lk_vec),
    .any_o    (lk_any),
    .first_o  (lk_idx)
  );

  // slot choice for insert-address
  logic [IW-1:0] rr_ptr, slot;
  logic          use_rr;

  range_tlb_pick #(.N(N_ENTRIES)) u_pick (
    .valid_i (valid_q),
    .cover_i (cm_vec & valid_q),
    .rr_i    (rr_ptr),
    .slot_o  (slot),
    .use_rr_o(use_rr)
  );

  range_tlb_rr #(.N(N_ENTRIES)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (ins_addr && use_rr),
    .ptr_o (rr_ptr)
  );

  // operand decode
  logic [VA_W-1:0]  page_lo, page_hi;
  logic [PPN_W-1:0] new_ppn;
  prot_t            new_prot;
  logic             prot_ok;

  assign page_lo  = cmd_addr_i & ~OFF_MASK;
  assign page_hi  = page_lo | OFF_MASK;
  assign new_ppn  = cmd_data_i[PPN_LSB +: PPN_W];
  assign new_prot = prot_t'(cmd_data_i[PROT_LSB +: PROT_W]);
  assign prot_ok  = cm_any && !valid_q[cm_idx];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic             wr_addr, wr_prot, clr;
    logic [VA_W-1:0]  lo_r, hi_r;
    logic [PPN_W-1:0] ppn_r;
    prot_t            prot_r;
    logic             valid_r;

    assign wr_addr = ins_addr && (slot == IW'(g));
    assign wr_prot = ins_prot && prot_ok && (cm_idx == IW'(g));
    assign clr     = purge_all
                  || (ins_addr && valid_r && cm_vec[g])
                  || (purge_va && cm_any && (cm_idx == IW'(g)) && valid_r);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_r    <= '1;
        hi_r    <= '0;
        ppn_r   <= '0;
        prot_r  <= '0;
        valid_r <= 1'b0;
      end else if (wr_addr) begin
        lo_r    <= page_lo;
        hi_r    <= page_hi;
        ppn_r   <= new_ppn;
        prot_r  <= '0;
        valid_r <= 1'b0;
      end else if (clr) begin
        lo_r    <= '1;
        hi_r    <= '0;
        ppn_r   <= '0;
        prot_r  <= '0;
        valid_r <= 1'b0;
      end else if (wr_prot) begin
        prot_r  <= new_prot;
        valid_r <= 1'b1;
      end
    end

    assign lo_q[g]    = lo_r;
    assign hi_q[g]    = hi_r;
    assign ppn_q[g]   = ppn_r;
    assign prot_q[g]  = prot_r;
    assign valid_q[g] = valid_r;
  end

  // rejected insert-protection pulse
  logic err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= ins_prot && !prot_ok;
  end
  assign cmd_err_o = err_q;

  // lookup result
  logic lk_hit;
  assign lk_hit    = lk_any && valid_q[lk_idx];
  assign lk_hit_o  = lk_hit;
  assign lk_pa_o   = lk_hit ? {ppn_q[lk_idx], lk_addr_i[PAGE_BITS-1:0]} : '0;
  assign lk_prot_o = lk_hit ? prot_q[lk_idx] : '0;

endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic [1:0]      cmd_op_i,
  input logic [VA_W-1:0] cmd_addr_i,
  input logic [VA_W-1:0] lk_addr_i,
  input logic            lk_hit_o,
  input logic            cmd_err_o
);

  p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $past(cmd_valid_i && cmd_op_i == 2'd1));

  p_ins_addr_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd0 && lk_addr_i == cmd_addr_i)
      |=> ($stable(lk_addr_i) |-> !lk_hit_o));

  p_ins_prot_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd1 && lk_addr_i == cmd_addr_i)
      |=> ($stable(lk_addr_i) |-> (lk_hit_o || cmd_err_o)));

  p_purge_va_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd2 && lk_addr_i == cmd_addr_i)
      |=> ($stable(lk_addr_i) |-> !lk_hit_o));

  p_purge_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3) |=> !lk_hit_o);

endmodule

bind range_tlb range_tlb_chk #(.VA_W(VA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_addr_i (cmd_addr_i),
  .lk_addr_i  (lk_addr_i),
  .lk_hit_o   (lk_hit_o),
  .cmd_err_o  (cmd_err_o)
);

// File: tb/range_tlb_bench.sv
`timescale 1ns/1ps
module range_tlb_bench;

  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'd0;
  logic [31:0] cmd_addr_i = '0;
  logic [31:0] cmd_data_i = '0;
  logic [31:0] lk_addr_i = '0;
  logic        lk_hit_o;
  logic [31:0] lk_pa_o;
  logic [28:0] lk_prot_o;
  logic        cmd_err_o;

  range_tlb #(.N_ENTRIES(N)) u_range_tlb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .lk_addr_i(lk_addr_i),
    .lk_hit_o(lk_hit_o), .lk_pa_o(lk_pa_o), .lk_prot_o(lk_prot_o), .cmd_err_o(cmd_err_o)
  );

  always #2.5 clk_i = ~clk_i;

  // reference model built from the requirements
  logic [31:0] mb [N];
  logic [31:0] me [N];
  logic [19:0] mp [N];
  logic [28:0] mpr[N];
  bit          mv [N];
  int          rr;

  typedef struct {
    bit          is_err;
    bit          exp_err;
    bit          hit;
    logic [31:0] pa;
    logic [28:0] prot;
    logic [31:0] addr;
    string       tag;
  } item_t;
  item_t sq[$];

  int checks = 0;
  int errors = 0;

  function automatic void mclear(int i);
    mb[i] = '1; me[i] = '0; mp[i] = '0; mpr[i] = '0; mv[i] = 0;
  endfunction

  function automatic int mfind(logic [31:0] a);
    for (int i = 0; i < N; i++) if (mb[i] <= a && a <= me[i]) return i;
    return -1;
  endfunction

  function automatic bit model_cmd(logic [1:0] op, logic [31:0] a, logic [31:0] d);
    int k;
    int slot;
    k = mfind(a);
    case (op)
      2'd0: begin
        slot = -1;
        for (int i = 0; i < N; i++) begin
          if (!mv[i]) slot = i;
          else if (mb[i] <= a && a <= me[i]) begin mclear(i); slot = i; end
        end
        if (slot < 0) begin slot = rr; rr = (rr == N - 1) ? 0 : rr + 1; end
        mclear(slot);
        mb[slot] = a & ~32'hFFF;
        me[slot] = mb[slot] | 32'hFFF;
        mp[slot] = d[24:5];
        return 0;
      end
      2'd1: begin
        if (k < 0 || mv[k]) return 1;
        mpr[k] = d[29:1];
        mv[k]  = 1;
        return 0;
      end
      2'd2: begin
        if (k >= 0 && mv[k]) mclear(k);
        return 0;
      end
      default: begin
        for (int i = 0; i < N; i++) mclear(i);
        return 0;
      end
    endcase
  endfunction

  task automatic push_look(input logic [31:0] a, input string tag);
    item_t it;
    int k;
    k = mfind(a);
    it.is_err = 0; it.exp_err = 0; it.addr = a; it.tag = tag;
    it.hit  = (k >= 0) && mv[k];
    it.pa   = it.hit ? {mp[k], a[11:0]} : 32'h0;
    it.prot = it.hit ? mpr[k] : 29'h0;
    sq.push_back(it);
  endtask

  task automatic push_err(input bit e, input string tag);
    item_t it;
    it.is_err = 1; it.exp_err = e; it.hit = 0; it.pa = '0; it.prot = '0;
    it.addr = '0; it.tag = tag;
    sq.push_back(it);
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    @(negedge clk_i);
    lk_addr_i = a;
    push_look(a, tag);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                     input string tag, input bit with_look = 0,
                     input logic [31:0] la = '0);
    bit e;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d;
    if (with_look) begin
      lk_addr_i = la;
      push_look(la, "R10");
    end
    e = model_cmd(op, a, d);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    push_err(e, tag);
  endtask

  function automatic logic [31:0] word(int i);
    return (i * 32'h9E37_79B9) ^ 32'h5A3C_96E1;
  endfunction

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (sq.size() > 0) begin
        item_t it;
        it = sq.pop_front();
        checks++;
        if (it.is_err) begin
          if (cmd_err_o !== it.exp_err) begin
            errors++;
            $display("FAIL %s cmd_err_o act=%0b exp=%0b", it.tag, cmd_err_o, it.exp_err);
          end
        end else if ({lk_hit_o, lk_pa_o, lk_prot_o} !== {it.hit, it.pa, it.prot}) begin
          errors++;
          $display("FAIL %s addr=%h act hit=%0b pa=%h prot=%h exp hit=%0b pa=%h prot=%h",
                   it.tag, it.addr, lk_hit_o, lk_pa_o, lk_prot_o, it.hit, it.pa, it.prot);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] A = 32'h0001_2345;
  localparam logic [31:0] B = 32'h0077_7000;

  initial begin
    for (int i = 0; i < N; i++) mclear(i);
    rr = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    push_err(0, "R1");
    look(32'h0, "R1");
    look(32'hFFFF_FFFF, "R1");
    look(A, "R1");

    // R2: address step alone leaves entry invalid
    cmd(2'd0, A, word(1), "R2");
    look(A, "R2");
    // R10: protection step with lookup in same cycle sees old state
    cmd(2'd1, A, word(2), "R3", 1, A);
    look(A, "R3");
    look(32'h0001_2000, "R4");
    look(32'h0001_2FFF, "R4");
    look(32'h0001_1FFF, "R4");
    look(32'h0001_3000, "R4");

    // R5: second protection step and unmatched address are rejected
    cmd(2'd1, A, word(3), "R5");
    look(A, "R5");
    cmd(2'd1, B, word(4), "R5");
    look(B, "R5");

    // R8: re-insert over a valid covering entry
    cmd(2'd0, A + 32'h10, word(5), "R8");
    look(A, "R8");
    cmd(2'd1, A, word(6), "R8");
    look(A + 32'h20, "R8");

    // R6: purge by address, lookup in same cycle still hits (R10)
    cmd(2'd0, B, word(7), "R6");
    cmd(2'd1, B, word(8), "R6");
    cmd(2'd2, A, 32'h0, "R6", 1, A);
    look(A, "R6");
    look(B, "R6");
    cmd(2'd2, 32'h0900_0000, 32'h0, "R6");
    look(B + 32'h123, "R6");

    // R7: purge all
    cmd(2'd7 & 2'd3, 32'h0, 32'h0, "R7");
    look(B, "R7");
    look(A, "R7");

    // R9: fill and evict with wrap
    for (int p = 0; p < 20; p++) begin
      cmd(2'd0, 32'h0010_0000 + p * 4096 + p, word(100 + p), "R9");
      cmd(2'd1, 32'h0010_0000 + p * 4096, word(200 + p), "R9");
      for (int q = 0; q <= p; q++) look(32'h0010_0000 + q * 4096 + 32'h7, "R9");
    end

    // R8 with a full buffer: covering entry is reused
    cmd(2'd0, 32'h0010_0000 + 15 * 4096, word(300), "R8");
    look(32'h0010_0000 + 15 * 4096, "R8");
    cmd(2'd1, 32'h0010_0000 + 15 * 4096, word(301), "R8");
    for (int q = 0; q < 20; q++) look(32'h0010_0000 + q * 4096 + 32'hABC, "R8");

    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule